// File: doc/BRIEF.md
# Disk Command Validator and Dispatcher

This block sits in front of the drives of a multi-drive cartridge disk controller. It takes a GO command: a 3-bit function code, a format-mode bit, and the disk address held in its own address register. The address names a drive, a cylinder and a sector. The block checks the command against the flags each drive reports: present, attached, busy and hardware write-protect. It also checks a software write-lock that it keeps per drive.

Each command has one of three outcomes:
- It finishes in the same cycle with an error or status result.
- It starts a seek on the selected drive and reports done at once.
- It starts a data transfer and holds done low until the transfer engine reports completion.

The error register collects error bits. Each non-reset command clears the soft group. Two summary bits are derived from the register.

Commands use a valid/ready pair. `cmd_ready` equals `done`, so a command waits whenever a transfer is in flight. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. There is no other back-pressure. The control and status pins are plain levels or one-cycle strobes. Every output is registered and changes on the edge that accepts the command.

Top module: `dkc_dispatch`

## Requirements
- R1: After reset, `done` and `cmd_ready` are 1. `err_q`, `da_q`, `sw_lock`, `scp`, `last_drive` and all strobes are 0.
- R2: Function 0 (control reset) does the following. Software locks are kept.
  - It clears `err_q`, `da_q` and `scp`.
  - It pulses `ctl_clr` and `done_pulse`.
  - It leaves `done` at 1.
  - It wins over an address write in the same cycle.
- R3: Any function other than 0 clears error bits 1:0 (soft group) and keeps all other error bits.
- R4: Any function other than 0 loads `last_drive` with address bits 15:13 and clears `scp`.
- R5: Checks run in this fixed order, and only the first failing check records its bit. Each failure ends with `done_pulse` and no start strobe.
  - Drive not present sets bit 7.
  - Drive not attached, or busy, sets bit 15.
  - Format mode with a function other than 1 (write) or 2 (read) sets bit 11.
  - Function 1 to a protected drive sets bit 13.
- R6: A drive is write-protected when its `drv_hwlock` input is set or its software lock is set.
- R7: Function 7 sets the drive's software lock and completes with no error. Function 6 clears that lock and issues a seek to cylinder 0, ignoring the sector and cylinder fields.
- R8: For functions 1 to 5, a sector field (bits 3:0) of 12 or more sets bit 5. Otherwise, a cylinder field (bits 12:5) of 203 or more sets bit 6.
- R9: A valid function 4 pulses `seek_start` with `tgt_drive` and `tgt_cyl`, keeps `done` at 1 and pulses `done_pulse`.
- R10: A valid function 1, 2, 3 or 5 does the following:
  - It pulses `xfer_start` with `xfer_func` and clears `done`.
  - The next `xfer_done` sets `done`, pulses `done_pulse` and ORs `xfer_err` into the register.
  - `xfer_done` while `done` is 1 is ignored.
  - A command is not accepted while `done` is 0.
- R11: `err_sum` is 1 when any error bit is set. `err_hard` is 1 when any of bits 15:5 is set.
- R12: `da_q` takes `da_wr_data` only while `done` is 1. Writes while `done` is 0 have no effect.
- R13: A command accepted in the same cycle as an address write uses the previous address. The written value is stored.
- R14: A `seek_cpl` pulse sets `scp`. It wins over a clear in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | GO command offered |
| cmd_ready | output | 1 | Command can be accepted (equals done) |
| cmd_func | input | 3 | Function code |
| cmd_fmt | input | 1 | Format mode bit |
| da_wr_en | input | 1 | Address register write enable |
| da_wr_data | input | 16 | Address register write value |
| drv_present | input | NDRV | Per-drive present flag |
| drv_attached | input | NDRV | Per-drive attached flag |
| drv_busy | input | NDRV | Per-drive busy flag |
| drv_hwlock | input | NDRV | Per-drive hardware write-protect |
| xfer_done | input | 1 | Transfer engine finished |
| xfer_err | input | 16 | Error bits reported with xfer_done |
| seek_cpl | input | 1 | A background seek has finished |
| da_q | output | 16 | Disk address register |
| done | output | 1 | Controller idle |
| done_pulse | output | 1 | One-cycle completion strobe |
| ctl_clr | output | 1 | Strobe to clear bus address and interrupt queue |
| err_q | output | 16 | Error register |
| err_sum | output | 1 | Any error |
| err_hard | output | 1 | Any hard error |
| scp | output | 1 | Search-complete flag |
| last_drive | output | 3 | Drive of last non-reset command |
| sw_lock | output | NDRV | Software write-lock per drive |
| seek_start | output | 1 | Seek start strobe |
| xfer_start | output | 1 | Transfer start strobe |
| tgt_drive | output | 3 | Drive for the start strobe |
| tgt_cyl | output | 8 | Cylinder for the start strobe |
| xfer_func | output | 3 | Function for the transfer strobe |

## Verification
An address write and a GO command can fall in the same cycle, and so can a control reset and an address write. The bench drives `da_wr_en` and `cmd_valid` in the same cycle. For a seek, it checks that `tgt_cyl` comes from the old address while `da_q` holds the new value. For a control reset, it checks that `da_q` ends at zero. `seek_cpl` can also meet a command's flag clear. This is judged by pulsing it around commands and reading `scp`.

// File: rtl/dkc_pkg.sv
package dkc_pkg;
  typedef enum logic [2:0] {
    F_CTLRST = 3'd0, F_WRITE = 3'd1, F_READ = 3'd2, F_WCHK = 3'd3,
    F_SEEK = 3'd4, F_RCHK = 3'd5, F_DRVRST = 3'd6, F_WLOCK = 3'd7
  } func_e;

  typedef enum logic [1:0] {OUT_FAIL, OUT_DONE, OUT_SEEK, OUT_XFER} outcome_e;

  localparam int ADDR_W   = 16;
  localparam int SECT_LSB = 0;
  localparam int SECT_W   = 4;
  localparam int CYL_LSB  = 5;
  localparam int CYL_W    = 8;
  localparam int DRV_LSB  = 13;
  localparam int DRV_W    = 3;

  localparam int E_NXS = 5;
  localparam int E_NXC = 6;
  localparam int E_NXD = 7;
  localparam int E_PGE = 11;
  localparam int E_WLK = 13;
  localparam int E_DRE = 15;

  localparam logic [ADDR_W-1:0] ERR_SOFT = 16'h0003;
  localparam logic [ADDR_W-1:0] ERR_HARD = 16'hFFE0;
  localparam logic [ADDR_W-1:0] ERR_IMPL = ERR_SOFT | ERR_HARD;
endpackage

// File: rtl/dkc_areg.sv
module dkc_areg
  import dkc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_en,
  input  logic              allow,
  input  logic [ADDR_W-1:0] wr_data,
  output logic [ADDR_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)               q <= '0;
    else if (clr)             q <= '0;
    else if (wr_en && allow)  q <= wr_data;
  end
endmodule

// File: rtl/dkc_errreg.sv
module dkc_errreg
  import dkc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_all,
  input  logic              clr_soft,
  input  logic [ADDR_W-1:0] set_bits,
  output logic [ADDR_W-1:0] q,
  output logic              any_err,
  output logic              hard_err
);
  logic [ADDR_W-1:0] kept;

  always_comb begin
    kept = clr_soft ? (q & ~ERR_SOFT) : q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       q <= '0;
    else if (clr_all) q <= '0;
    else              q <= (kept | set_bits) & ERR_IMPL;
  end

  assign any_err  = |q;
  assign hard_err = |(q & ERR_HARD);
endmodule

// File: rtl/dkc_check.sv
module dkc_check
  import dkc_pkg::*;
#(
  parameter int NDRV  = 8,
  parameter int NSECT = 12,
  parameter int NCYL  = 203
) (
  input  func_e             func,
  input  logic              fmt,
  input  logic [ADDR_W-1:0] da,
  input  logic [NDRV-1:0]   pres,
  input  logic [NDRV-1:0]   att,
  input  logic [NDRV-1:0]   busy,
  input  logic [NDRV-1:0]   lockd,
  output outcome_e          outcome,
  output logic [ADDR_W-1:0] err_bit,
  output logic [CYL_W-1:0]  cyl
);
  localparam int NSLOT = 1 << DRV_W;

  logic [NSLOT-1:0]  p_pad, a_pad, b_pad, l_pad;
  logic [DRV_W-1:0]  drv;
  logic [SECT_W-1:0] sect;
  logic [CYL_W-1:0]  cyl_f;

  always_comb begin
    p_pad = '0; a_pad = '0; b_pad = '0; l_pad = '0;
    p_pad[NDRV-1:0] = pres;
    a_pad[NDRV-1:0] = att;
    b_pad[NDRV-1:0] = busy;
    l_pad[NDRV-1:0] = lockd;
    drv   = da[DRV_LSB +: DRV_W];
    sect  = da[SECT_LSB +: SECT_W];
    cyl_f = da[CYL_LSB +: CYL_W];

    outcome = OUT_FAIL;
    err_bit = '0;
    cyl     = cyl_f;
    if (!p_pad[drv])                                 err_bit[E_NXD] = 1'b1;
    else if (!a_pad[drv] || b_pad[drv])              err_bit[E_DRE] = 1'b1;
    else if (fmt && func != F_READ && func != F_WRITE) err_bit[E_PGE] = 1'b1;
    else if (func == F_WRITE && l_pad[drv])          err_bit[E_WLK] = 1'b1;
    else if (func == F_WLOCK)                        outcome = OUT_DONE;
    else if (func == F_DRVRST) begin
      cyl     = '0;
      outcome = OUT_SEEK;
    end
    else if (int'(sect) >= NSECT)                    err_bit[E_NXS] = 1'b1;
    else if (int'(cyl_f) >= NCYL)                    err_bit[E_NXC] = 1'b1;
    else if (func == F_SEEK)                         outcome = OUT_SEEK;
    else                                             outcome = OUT_XFER;
  end
endmodule

// File: rtl/dkc_dispatch.sv
module dkc_dispatch
  import dkc_pkg::*;
#(
  parameter int NDRV  = 8,
  parameter int NSECT = 12,
  parameter int NCYL  = 203
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_func,
  input  logic              cmd_fmt,
  input  logic              da_wr_en,
  input  logic [15:0]       da_wr_data,
  input  logic [NDRV-1:0]   drv_present,
  input  logic [NDRV-1:0]   drv_attached,
  input  logic [NDRV-1:0]   drv_busy,
  input  logic [NDRV-1:0]   drv_hwlock,
  input  logic              xfer_done,
  input  logic [15:0]       xfer_err,
  input  logic              seek_cpl,
  output logic [15:0]       da_q,
  output logic              done,
  output logic              done_pulse,
  output logic              ctl_clr,
  output logic [15:0]       err_q,
  output logic              err_sum,
  output logic              err_hard,
  output logic              scp,
  output logic [2:0]        last_drive,
  output logic [NDRV-1:0]   sw_lock,
  output logic              seek_start,
  output logic              xfer_start,
  output logic [2:0]        tgt_drive,
  output logic [7:0]        tgt_cyl,
  output logic [2:0]        xfer_func
);
  func_e             func;
  outcome_e          outcome;
  logic [ADDR_W-1:0] chk_err;
  logic [CYL_W-1:0]  chk_cyl;
  logic [DRV_W-1:0]  cmd_drv;
  logic              accept, is_rst, is_cmd, xfer_fin;
  logic              lock_hit, unlock_hit;
  logic [ADDR_W-1:0] err_set;

  assign func       = func_e'(cmd_func);
  assign cmd_ready  = done;
  assign accept     = cmd_valid && done;
  assign is_rst     = accept && (func == F_CTLRST);
  assign is_cmd     = accept && (func != F_CTLRST);
  assign xfer_fin   = xfer_done && !done;
  assign cmd_drv    = da_q[DRV_LSB +: DRV_W];
  assign lock_hit   = is_cmd && (outcome == OUT_DONE);
  assign unlock_hit = is_cmd && (outcome == OUT_SEEK) && (func == F_DRVRST);
  assign err_set    = is_cmd ? chk_err : (xfer_fin ? xfer_err : '0);

  dkc_areg u_areg (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (is_rst),
    .wr_en  (da_wr_en),
    .allow  (done),
    .wr_data(da_wr_data),
    .q      (da_q)
  );

  dkc_check #(.NDRV(NDRV), .NSECT(NSECT), .NCYL(NCYL)) u_check (
    .func   (func),
    .fmt    (cmd_fmt),
    .da     (da_q),
    .pres   (drv_present),
    .att    (drv_attached),
    .busy   (drv_busy),
    .lockd  (drv_hwlock | sw_lock),
    .outcome(outcome),
    .err_bit(chk_err),
    .cyl    (chk_cyl)
  );

  dkc_errreg u_err (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_all (is_rst),
    .clr_soft(is_cmd),
    .set_bits(err_set),
    .q       (err_q),
    .any_err (err_sum),
    .hard_err(err_hard)
  );

  for (genvar g = 0; g < NDRV; g++) begin : g_lock
    always_ff @(posedge clk) begin
      if (!rst_n)                                 sw_lock[g] <= 1'b0;
      else if (lock_hit && int'(cmd_drv) == g)    sw_lock[g] <= 1'b1;
      else if (unlock_hit && int'(cmd_drv) == g)  sw_lock[g] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done       <= 1'b1;
      done_pulse <= 1'b0;
      ctl_clr    <= 1'b0;
      scp        <= 1'b0;
      last_drive <= '0;
      seek_start <= 1'b0;
      xfer_start <= 1'b0;
      tgt_drive  <= '0;
      tgt_cyl    <= '0;
      xfer_func  <= '0;
    end else begin
      ctl_clr    <= is_rst;
      seek_start <= is_cmd && (outcome == OUT_SEEK);
      xfer_start <= is_cmd && (outcome == OUT_XFER);
      done_pulse <= is_rst || (is_cmd && outcome != OUT_XFER) || xfer_fin;
      if (is_cmd && outcome == OUT_XFER) done <= 1'b0;
      else if (xfer_fin)                 done <= 1'b1;
      if (seek_cpl)    scp <= 1'b1;
      else if (accept) scp <= 1'b0;
      if (is_cmd) begin
        last_drive <= cmd_drv;
        tgt_drive  <= cmd_drv;
        tgt_cyl    <= chk_cyl;
        xfer_func  <= cmd_func;
      end
    end
  end
endmodule

// File: rtl/dkc_dispatch_chk.sv
module dkc_dispatch_chk #(
  parameter int NDRV = 8
) (
  input logic        clk,
  input logic        rst_n,
  input logic        done,
  input logic        done_pulse,
  input logic        seek_start,
  input logic        xfer_start,
  input logic        ctl_clr,
  input logic        err_sum,
  input logic        err_hard,
  input logic [15:0] err_q,
  input logic [15:0] da_q
);
  // R9
  seek_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seek_start |-> done);

  // R10
  xfer_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |-> !done);

  // R5
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({seek_start, xfer_start, ctl_clr}));

  // R11
  hard_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_hard |-> err_sum);

  // R12
  da_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(da_q));

  // R2
  ctl_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_clr |-> (err_q == 16'h0 && da_q == 16'h0 && done_pulse));

  // R10
  pulse_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> done);
endmodule

bind dkc_dispatch dkc_dispatch_chk #(.NDRV(NDRV)) u_chk (.*);

// File: tb/dkc_dispatch_tb.sv
`timescale 1ns/1ps
module dkc_dispatch_tb;
  localparam int NDRV = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_fmt = 1'b0, da_wr_en = 1'b0;
  logic xfer_done = 1'b0, seek_cpl = 1'b0;
  logic [2:0] cmd_func = '0;
  logic [15:0] da_wr_data = '0, xfer_err = '0;
  logic [NDRV-1:0] drv_present = '1, drv_attached = '1, drv_busy = '0, drv_hwlock = '0;
  logic cmd_ready, done, done_pulse, ctl_clr, err_sum, err_hard, scp;
  logic seek_start, xfer_start;
  logic [15:0] da_q, err_q;
  logic [2:0] last_drive, tgt_drive, xfer_func;
  logic [7:0] tgt_cyl;
  logic [NDRV-1:0] sw_lock;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  dkc_dispatch #(.NDRV(NDRV)) u_dut (.*);

  // {da, func, fmt, {present,attached,busy,hwlock}, expected err, kind(0 done,1 seek,2 xfer), pad}
  localparam int NV = 25;
  localparam logic [47:0] VEC [NV] = '{
    {16'h2143, 3'd2, 1'b0, 4'b1100, 16'h0000, 2'd2, 6'd0}, // R10 read
    {16'h4C80, 3'd4, 1'b0, 4'b1100, 16'h0000, 2'd1, 6'd0}, // R9 seek cyl 100
    {16'h6000, 3'd2, 1'b0, 4'b0110, 16'h0080, 2'd0, 6'd0}, // R5 absent
    {16'h8000, 3'd4, 1'b0, 4'b1000, 16'h8000, 2'd0, 6'd0}, // R5 not attached
    {16'h8000, 3'd2, 1'b0, 4'b1110, 16'h8000, 2'd0, 6'd0}, // R5 busy
    {16'h2000, 3'd4, 1'b1, 4'b1100, 16'h0800, 2'd0, 6'd0}, // R5 format seek
    {16'h2000, 3'd2, 1'b1, 4'b1100, 16'h0000, 2'd2, 6'd0}, // R5 format read ok
    {16'h2000, 3'd1, 1'b1, 4'b1100, 16'h0000, 2'd2, 6'd0}, // R5 format write ok
    {16'hA000, 3'd1, 1'b0, 4'b1101, 16'h2000, 2'd0, 6'd0}, // R6 hw lock write
    {16'hA000, 3'd2, 1'b0, 4'b1101, 16'h0000, 2'd2, 6'd0}, // R6 hw lock read ok
    {16'hA000, 3'd1, 1'b0, 4'b1111, 16'h8000, 2'd0, 6'd0}, // R5 busy beats lock
    {16'hC000, 3'd4, 1'b1, 4'b0000, 16'h0080, 2'd0, 6'd0}, // R5 absent first
    {16'h4000, 3'd7, 1'b1, 4'b1100, 16'h0800, 2'd0, 6'd0}, // R5 format lock
    {16'h200C, 3'd2, 1'b0, 4'b1100, 16'h0020, 2'd0, 6'd0}, // R8 sector 12
    {16'h3960, 3'd2, 1'b0, 4'b1100, 16'h0040, 2'd0, 6'd0}, // R8 cyl 203
    {16'h3FEF, 3'd4, 1'b0, 4'b1100, 16'h0020, 2'd0, 6'd0}, // R8 sector first
    {16'h394B, 3'd2, 1'b0, 4'b1100, 16'h0000, 2'd2, 6'd0}, // R8 edges ok
    {16'hF940, 3'd4, 1'b0, 4'b1100, 16'h0000, 2'd1, 6'd0}, // R9 drive 7
    {16'h6000, 3'd7, 1'b0, 4'b1100, 16'h0000, 2'd0, 6'd0}, // R7 soft lock
    {16'h6000, 3'd1, 1'b0, 4'b1100, 16'h2000, 2'd0, 6'd0}, // R6 soft lock write
    {16'h7FEF, 3'd6, 1'b0, 4'b1100, 16'h0000, 2'd1, 6'd0}, // R7 drive reset
    {16'h6000, 3'd1, 1'b0, 4'b1100, 16'h0000, 2'd2, 6'd0}, // R7 unlocked write
    {16'h0025, 3'd3, 1'b0, 4'b1100, 16'h0000, 2'd2, 6'd0}, // R10 write check
    {16'h0025, 3'd5, 1'b0, 4'b1100, 16'h0000, 2'd2, 6'd0}, // R10 read check
    {16'h6000, 3'd6, 1'b0, 4'b1110, 16'h8000, 2'd0, 6'd0}  // R5 busy reset
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] f, input logic fm);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_func = f; cmd_fmt = fm;
    @(posedge clk); #1;
    cmd_valid = 1'b0; cmd_fmt = 1'b0;
  endtask

  task automatic wr_da(input logic [15:0] v);
    @(negedge clk);
    da_wr_en = 1'b1; da_wr_data = v;
    @(posedge clk); #1;
    da_wr_en = 1'b0;
  endtask

  task automatic fin_xfer(input logic [15:0] e);
    @(negedge clk);
    xfer_done = 1'b1; xfer_err = e;
    @(posedge clk); #1;
    xfer_done = 1'b0; xfer_err = '0;
  endtask

  task automatic pulse_scp();
    @(negedge clk);
    seek_cpl = 1'b1;
    @(posedge clk); #1;
    seek_cpl = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 done", done, 1);
    chk("R1 ready", cmd_ready, 1);
    chk("R1 err", err_q, 0);
    chk("R1 da", da_q, 0);
    chk("R1 lock", sw_lock, 0);
    chk("R1 strobes", {seek_start, xfer_start, ctl_clr, done_pulse, scp}, 0);
    chk("R1 last", last_drive, 0);

    for (int i = 0; i < NV; i++) begin
      logic [47:0] v;
      int d;
      logic [2:0] f;
      logic [15:0] ee;
      logic [1:0] k;
      v = VEC[i];
      d = int'(v[47:45]);
      f = v[31:29];
      ee = v[23:8];
      k = v[7:6];
      issue(3'd0, 1'b0);
      wr_da(v[47:32]);
      drv_present = '1; drv_attached = '1; drv_busy = '0; drv_hwlock = '0;
      drv_present[d] = v[27]; drv_attached[d] = v[26];
      drv_busy[d] = v[25]; drv_hwlock[d] = v[24];
      issue(f, v[28]);
      chk($sformatf("R5/R8 err vec %0d", i), err_q, ee);
      chk($sformatf("R11 sum vec %0d", i), err_sum, |ee);
      chk($sformatf("R11 hard vec %0d", i), err_hard, |ee[15:5]);
      chk($sformatf("R4 last vec %0d", i), last_drive, d);
      chk($sformatf("R9 seek vec %0d", i), seek_start, k == 2'd1);
      chk($sformatf("R10 xfer vec %0d", i), xfer_start, k == 2'd2);
      chk($sformatf("R10 done vec %0d", i), done, k != 2'd2);
      chk($sformatf("R9 pulse vec %0d", i), done_pulse, k != 2'd2);
      if (k == 2'd1) begin
        chk($sformatf("R7/R9 cyl vec %0d", i), tgt_cyl, (f == 3'd6) ? 8'd0 : v[44:37]);
        chk($sformatf("R9 drive vec %0d", i), tgt_drive, d);
      end
      if (f == 3'd7 && ee == 0) chk($sformatf("R7 lock set vec %0d", i), sw_lock[d], 1);
      if (f == 3'd6 && k == 2'd1) chk($sformatf("R7 lock clr vec %0d", i), sw_lock[d], 0);
      if (f == 3'd7 && ee != 0) chk($sformatf("R7 no lock vec %0d", i), sw_lock[d], 0);
      if (k == 2'd2) begin
        chk($sformatf("R10 func vec %0d", i), xfer_func, f);
        chk($sformatf("R10 tdrv vec %0d", i), tgt_drive, d);
        fin_xfer(16'h0);
        chk($sformatf("R10 fin done vec %0d", i), done, 1);
        chk($sformatf("R10 fin pulse vec %0d", i), done_pulse, 1);
      end
      drv_present = '1; drv_attached = '1; drv_busy = '0; drv_hwlock = '0;
    end

    // R3 soft errors cleared by the next command, hard kept
    issue(3'd0, 1'b0);
    wr_da(16'h2143);
    issue(3'd2, 1'b0);
    fin_xfer(16'h0023);
    chk("R10 err merge", err_q, 16'h0023);
    chk("R11 hard", err_hard, 1);
    issue(3'd4, 1'b0);
    chk("R3 soft clear", err_q, 16'h0020);
    chk("R3 sum kept", err_sum, 1);
    // R10 xfer_done while idle is ignored
    fin_xfer(16'h0080);
    chk("R10 idle fin err", err_q, 16'h0020);
    chk("R10 idle fin pulse", done_pulse, 0);

    // R14 seek complete sets scp, R2 control reset clears everything
    pulse_scp();
    chk("R14 scp set", scp, 1);
    issue(3'd0, 1'b0);
    chk("R2 err", err_q, 0);
    chk("R2 da", da_q, 0);
    chk("R2 scp", scp, 0);
    chk("R2 ctl_clr", ctl_clr, 1);
    chk("R2 pulse", done_pulse, 1);
    chk("R2 done", done, 1);
    @(posedge clk); #1;
    chk("R2 ctl_clr one cycle", ctl_clr, 0);

    // R4 a new command clears scp
    wr_da(16'h2143);
    pulse_scp();
    issue(3'd4, 1'b0);
    chk("R4 scp clear", scp, 0);

    // R12 address writes ignored while busy; R10 no accept while busy
    issue(3'd2, 1'b0);
    chk("R10 busy ready", cmd_ready, 0);
    wr_da(16'h5555);
    chk("R12 da held", da_q, 16'h2143);
    issue(3'd4, 1'b0);
    chk("R10 no accept", {seek_start, xfer_start}, 0);
    chk("R10 still busy", done, 0);
    fin_xfer(16'h0);
    chk("R10 back idle", done, 1);

    // R13 address write and command in the same cycle
    @(negedge clk);
    da_wr_en = 1'b1; da_wr_data = 16'h4C80;
    cmd_valid = 1'b1; cmd_func = 3'd4;
    @(posedge clk); #1;
    da_wr_en = 1'b0; cmd_valid = 1'b0;
    chk("R13 old cyl", tgt_cyl, 8'd10);
    chk("R13 old drive", tgt_drive, 3'd1);
    chk("R13 new da", da_q, 16'h4C80);
    // R2 control reset wins over a same-cycle write
    @(negedge clk);
    da_wr_en = 1'b1; da_wr_data = 16'h1234;
    cmd_valid = 1'b1; cmd_func = 3'd0;
    @(posedge clk); #1;
    da_wr_en = 1'b0; cmd_valid = 1'b0;
    chk("R2 reset beats write", da_q, 16'h0);

    // R14 seek complete wins over a command clear in the same cycle
    wr_da(16'h2143);
    @(negedge clk);
    seek_cpl = 1'b1; cmd_valid = 1'b1; cmd_func = 3'd4;
    @(posedge clk); #1;
    seek_cpl = 1'b0; cmd_valid = 1'b0;
    chk("R14 set wins", scp, 1);

    summary();
    $finish;
  end
endmodule